// File: doc/BRIEF.md
# Serial Flash Programming Sequencer

This block is the host side of a two-wire serial programming link used to write a target device's code memory. It drives a programming clock and a data line with a separate output enable, so the data pin can be built as a tri-state pad outside the block. Every transaction on the wires is a 4-bit command followed by a 16-bit payload, both sent least significant bit first. All minimum delays are parameters counted in system clock cycles, and so is the half-period of the programming clock.

A host supplies requests over a valid/ready handshake. A request has a kind, a command and a payload. A raw request sends its command and payload unchanged. Load requests fill the target's write buffer. Each load carries two bytes, so a buffer of BUF_BYTES needs BUF_BYTES/2 loads. The sequencer picks the load command by itself for every load except the last. The last load goes out with the start-programming command. It is then followed by a NOP whose fourth clock pulse is held high for the programming time, then a low discharge interval, then a zero payload. An erase request sends the given command and payload (the host supplies the erase-key write), then a NOP with normal pulses, a low hold for the erase time plus the discharge time, and a zero payload.

Between the first and the last load, requests of any other kind are held off. No transaction can move the target's address pointer between filling the buffer and starting the write.

Top module: `sprog_seq`

## Requirements
- R1: After reset, pgc and pgd_oe are low, busy is low and req_ready is high while no request is pending.
- R2: A raw request (req_kind 0) puts its 4 command bits and then its 16 payload bits on pgd_out, least significant bit first. Each bit is valid at a rising edge of pgc, and pgd_oe is high at every rising edge.
- R3: Outside the stretched pulse, each pgc high phase and each pgc low phase inside one field lasts exactly DIV system cycles. pgd_out changes only together with a rising pgc edge, and pgd_oe rises only together with pgc.
- R4: Between the last command bit and the first payload bit, pgc stays low for at least P5 cycles. After a payload that is followed by a further command in the same sequence, it stays low for at least P5A cycles.
- R5: Load requests (req_kind 1) are sent with command LOAD_CMD (default 4'b1101), except every (BUF_BYTES/2)-th one, which is sent with command 4'b1111.
- R6: Once a load has been accepted and until the buffer's last load is accepted, req_ready is low for any request whose kind is not load, and no pgc pulse is produced for it.
- R7: After the payload of the 4'b1111 command, a NOP (command 0000) follows. Its first three pulses are normal and its fourth pulse stays high for exactly P9 cycles.
- R8: After the stretched pulse, pgc stays low for at least P10 cycles, and then a 16-bit zero payload is sent.
- R9: An erase request (req_kind 2) sends its command and payload, then a NOP with four normal pulses, then holds pgc low for at least P11+P10 cycles, then sends a 16-bit zero payload.
- R10: busy rises the cycle after acceptance and stays high until at least P5A cycles after the last falling pgc edge of the sequence. While busy is low, pgc stays low.
- R11: pgd_oe is low whenever busy is low, and low during every gap or hold in which pgc stays low for longer than one half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_kind | input | 2 | 0 raw, 1 buffer load, 2 erase |
| req_cmd | input | 4 | Command for raw and erase requests |
| req_data | input | 16 | Payload word |
| busy | output | 1 | Sequence in progress |
| pgc | output | 1 | Programming clock |
| pgd_out | output | 1 | Data driven onto the data line |
| pgd_oe | output | 1 | Drive enable for the data line |

## Verification
The bench goes after the stretched fourth NOP pulse. A design that stretched the wrong pulse, or stretched it by a half-period count, would show a high time other than P9 on pulse 24. It checks the low intervals against P5, P5A, P10 and P11+P10; a design that shared one delay value across the stages would come up short on the erase hold. It offers a raw request halfway through a buffer fill: a design without the hold-off would clock out a transaction that can move the pointer. It also checks that the command changes only on the final load and that the data line is released during long low holds, where a design that left the enable on would fight the target.

// File: rtl/sprog_pkg.sv
// Shared types and command codes for the serial programming sequencer.
package sprog_pkg;

    // Request kinds as seen on req_kind
    typedef enum logic [1:0] {
        OP_RAW   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    // What follows the first transaction of a sequence
    typedef enum logic [1:0] {
        T_NONE  = 2'd0,
        T_PROG  = 2'd1,
        T_ERASE = 2'd2
    } tail_e;

    // Sequencer states
    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_CMD   = 4'd1,
        S_GAP5  = 4'd2,
        S_DATA  = 4'd3,
        S_GAP5A = 4'd4,
        S_NCMD  = 4'd5,
        S_DISCH = 4'd6,
        S_NDATA = 4'd7,
        S_TAIL  = 4'd8
    } state_e;

    localparam logic [3:0] CMD_NOP   = 4'b0000;
    localparam logic [3:0] CMD_START = 4'b1111;

endpackage

// File: rtl/sprog_shifter.sv
// Bit serializer. On start it clocks out nbits of data, least significant
// bit first. Each bit is a high phase and then a low phase of DIV cycles.
// The data bit changes together with the rising clock. When stretch is set,
// the high phase of the last bit lasts hold cycles instead. The enable drops
// and done pulses once the low phase of the last bit ends.
// Assumes: DIV >= 1, hold >= 1, nbits in 1..16, start only while idle.
module sprog_shifter #(
    parameter int DIV = 4,
    parameter int CW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [4:0]    nbits,
    input  logic [15:0]   data,
    input  logic          stretch,
    input  logic [CW-1:0] hold,
    output logic          sclk,
    output logic          sdat,
    output logic          soe,
    output logic          done
);
    localparam logic [CW-1:0] HALF_M1 = CW'(DIV - 1);

    logic          active;
    logic          hi;
    logic [4:0]    idx;
    logic [4:0]    nxt;
    logic [4:0]    nbits_q;
    logic [15:0]   sreg;
    logic          stretch_q;
    logic [CW-1:0] hold_q;
    logic [CW-1:0] cnt;
    logic          last_bit;
    logic          next_last;

    // Index of the next bit and whether it, or the current one, is the last
    always_comb begin
        nxt       = idx + 5'd1;
        last_bit  = (idx == nbits_q - 5'd1);
        next_last = (nxt == nbits_q - 5'd1);
    end

    // Phase counter and bit stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            hi        <= 1'b0;
            idx       <= '0;
            nbits_q   <= '0;
            sreg      <= '0;
            stretch_q <= 1'b0;
            hold_q    <= '0;
            cnt       <= '0;
            sclk      <= 1'b0;
            sdat      <= 1'b0;
            soe       <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active    <= 1'b1;
                hi        <= 1'b1;
                idx       <= '0;
                nbits_q   <= nbits;
                sreg      <= data;
                stretch_q <= stretch;
                hold_q    <= hold;
                sclk      <= 1'b1;
                sdat      <= data[0];
                soe       <= 1'b1;
                cnt       <= (stretch && nbits == 5'd1) ? hold - 1'b1 : HALF_M1;
            end else if (active) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (hi) begin
                    hi   <= 1'b0;
                    sclk <= 1'b0;
                    cnt  <= HALF_M1;
                end else if (last_bit) begin
                    active <= 1'b0;
                    soe    <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx  <= nxt;
                    hi   <= 1'b1;
                    sclk <= 1'b1;
                    sdat <= sreg[nxt[3:0]];
                    cnt  <= (stretch_q && next_last) ? hold_q - 1'b1 : HALF_M1;
                end
            end
        end
    end

endmodule

// File: rtl/sprog_timer.sv
// One-shot delay. On start it loads val, and done pulses val cycles later.
// Assumes: val >= 1, start only while the timer is not running.
module sprog_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] val,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic          run;

    // Countdown with a done pulse on the last count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt <= val;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sprog_fill.sv
// Write-buffer fill tracker. It counts accepted loads modulo WORDS.
// filling is high while part of the buffer is loaded. last marks that the
// next load completes the buffer.
// Assumes: WORDS >= 1.
module sprog_fill #(
    parameter int WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_acc,
    output logic filling,
    output logic last
);
    localparam int FW = (WORDS > 2) ? $clog2(WORDS) : 1;
    localparam logic [FW-1:0] TOP = FW'(WORDS - 1);

    logic [FW-1:0] cnt;

    // Flags derived from the word count
    always_comb begin
        filling = (cnt != '0);
        last    = (cnt == TOP);
    end

    // Load counter, wrapping once the buffer is full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_acc) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sprog_seq.sv
// Serial programming sequencer top. It accepts raw, load and erase requests
// and runs each as command, gap, payload and gap. Start and erase sequences
// go on with a NOP, a timed low hold and a zero payload. Between the first
// and the last load, only further loads are accepted.
// Assumes: all timing parameters >= 1, with P9 >= DIV.
module sprog_seq
    import sprog_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int P5        = 8,
    parameter int P5A       = 8,
    parameter int P9        = 40000,
    parameter int P10       = 4000,
    parameter int P11       = 200000,
    parameter int BUF_BYTES = 8,
    parameter logic [3:0] LOAD_CMD = 4'b1101
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [3:0]  req_cmd,
    input  logic [15:0] req_data,
    output logic        busy,
    output logic        pgc,
    output logic        pgd_out,
    output logic        pgd_oe
);
    localparam int WORDS = (BUF_BYTES >= 2) ? BUF_BYTES / 2 : 1;
    localparam int CW    = $clog2(P11 + P10 + P9 + P5 + P5A + DIV + 2);
    localparam logic [CW-1:0] T5     = CW'(P5);
    localparam logic [CW-1:0] T5A    = CW'(P5A);
    localparam logic [CW-1:0] THOLD  = CW'(P9);
    localparam logic [CW-1:0] TDIS   = CW'(P10);
    localparam logic [CW-1:0] TERASE = CW'(P11 + P10);

    state_e        state;
    tail_e         tail;
    tail_e         tail_pick;
    logic [3:0]    cmd_pick;
    logic [15:0]   pay_q;
    logic          is_load;
    logic          acc;
    logic          fill_busy;
    logic          fill_last;
    logic          sh_start;
    logic [4:0]    sh_nbits;
    logic [15:0]   sh_data;
    logic          sh_stretch;
    logic          sh_done;
    logic          tm_start;
    logic [CW-1:0] tm_val;
    logic          tm_done;

    // Handshake: idle, and during a buffer fill only loads may enter
    always_comb begin
        is_load   = (req_kind == OP_LOAD);
        req_ready = (state == S_IDLE) && (!fill_busy || is_load);
        acc       = req_valid && req_ready;
        busy      = (state != S_IDLE);
    end

    // Choice of command and tail sequence for an incoming request
    always_comb begin
        cmd_pick  = req_cmd;
        tail_pick = T_NONE;
        if (is_load) begin
            cmd_pick  = fill_last ? CMD_START : LOAD_CMD;
            tail_pick = fill_last ? T_PROG : T_NONE;
        end else if (req_kind == OP_ERASE) begin
            tail_pick = T_ERASE;
        end
    end

    // Sequence state machine, launching shifts and delays
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            tail       <= T_NONE;
            pay_q      <= '0;
            sh_start   <= 1'b0;
            sh_nbits   <= '0;
            sh_data    <= '0;
            sh_stretch <= 1'b0;
            tm_start   <= 1'b0;
            tm_val     <= '0;
        end else begin
            sh_start <= 1'b0;
            tm_start <= 1'b0;
            case (state)
                S_IDLE: if (acc) begin
                    state      <= S_CMD;
                    pay_q      <= req_data;
                    tail       <= tail_pick;
                    sh_start   <= 1'b1;
                    sh_nbits   <= 5'd4;
                    sh_data    <= {12'd0, cmd_pick};
                    sh_stretch <= 1'b0;
                end
                S_CMD: if (sh_done) begin
                    state    <= S_GAP5;
                    tm_start <= 1'b1;
                    tm_val   <= T5;
                end
                S_GAP5: if (tm_done) begin
                    state      <= S_DATA;
                    sh_start   <= 1'b1;
                    sh_nbits   <= 5'd16;
                    sh_data    <= pay_q;
                    sh_stretch <= 1'b0;
                end
                S_DATA: if (sh_done) begin
                    state    <= S_GAP5A;
                    tm_start <= 1'b1;
                    tm_val   <= T5A;
                end
                S_GAP5A: if (tm_done) begin
                    if (tail == T_NONE) begin
                        state <= S_IDLE;
                    end else begin
                        state      <= S_NCMD;
                        sh_start   <= 1'b1;
                        sh_nbits   <= 5'd4;
                        sh_data    <= {12'd0, CMD_NOP};
                        sh_stretch <= (tail == T_PROG);
                    end
                end
                S_NCMD: if (sh_done) begin
                    state    <= S_DISCH;
                    tm_start <= 1'b1;
                    tm_val   <= (tail == T_ERASE) ? TERASE : TDIS;
                end
                S_DISCH: if (tm_done) begin
                    state      <= S_NDATA;
                    sh_start   <= 1'b1;
                    sh_nbits   <= 5'd16;
                    sh_data    <= '0;
                    sh_stretch <= 1'b0;
                end
                S_NDATA: if (sh_done) begin
                    state    <= S_TAIL;
                    tm_start <= 1'b1;
                    tm_val   <= T5A;
                end
                S_TAIL: if (tm_done) begin
                    state <= S_IDLE;
                    tail  <= T_NONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    sprog_fill #(.WORDS(WORDS)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_acc (acc && is_load),
        .filling  (fill_busy),
        .last     (fill_last)
    );

    sprog_shifter #(.DIV(DIV), .CW(CW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .nbits   (sh_nbits),
        .data    (sh_data),
        .stretch (sh_stretch),
        .hold    (THOLD),
        .sclk    (pgc),
        .sdat    (pgd_out),
        .soe     (pgd_oe),
        .done    (sh_done)
    );

    sprog_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tm_start),
        .val   (tm_val),
        .done  (tm_done)
    );

endmodule

// File: rtl/sprog_seq_chk.sv
// Protocol checker for sprog_seq, attached by bind below. It watches the
// wire outputs, busy, the handshake and the fill flag.
module sprog_seq_chk #(
    parameter int P9 = 40000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       busy,
    input logic       pgc,
    input logic       pgd_out,
    input logic       pgd_oe,
    input logic       filling
);
    int hi_cnt;

    // Length of the current high phase of pgc, in cycles
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= 0;
        else if (pgc) hi_cnt <= hi_cnt + 1;
        else hi_cnt <= 0;
    end

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgc && $past(pgc)) |-> $stable(pgd_out));

    // R3
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgd_oe) |-> $rose(pgc));

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pgd_oe);

    // R10
    idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pgc);

    // R6
    fill_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filling && req_valid && req_kind != 2'd1) |-> !req_ready);

    // R7
    stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgc |-> (hi_cnt < P9));

endmodule

bind sprog_seq sprog_seq_chk #(.P9(P9)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .busy      (busy),
    .pgc       (pgc),
    .pgd_out   (pgd_out),
    .pgd_oe    (pgd_oe),
    .filling   (fill_busy)
);

// File: tb/sim_sprog_seq.sv
// Directed bench for sprog_seq: one task per scenario, each checking itself.
module sim_sprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2, P5 = 3, P5A = 4, P9 = 40, P10 = 25, P11 = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [3:0]  req_cmd = 4'd0;
    logic [15:0] req_data = 16'd0;
    logic        busy, pgc, pgd_out, pgd_oe;

    int n_chk = 0, n_fail = 0;

    // Monitor state
    int n_ev = 0, lowcnt = 0, hicnt = 0, bad_oe = 0, idle_rise = 0, tail_low = 0;
    bit prev_pgc = 1'b0, prev_busy = 1'b0;
    bit ev_bit [64];
    bit ev_oe  [64];
    int ev_low [64];
    int ev_high[64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sprog_seq #(.DIV(DIV), .P5(P5), .P5A(P5A), .P9(P9), .P10(P10), .P11(P11)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_cmd(req_cmd), .req_data(req_data),
        .busy(busy), .pgc(pgc), .pgd_out(pgd_out), .pgd_oe(pgd_oe)
    );

    // Wire monitor, sampled on the falling system clock
    always @(negedge clk) begin
        if (pgc && !prev_pgc) begin
            if (n_ev < 64) begin
                ev_bit[n_ev] = pgd_out;
                ev_oe[n_ev]  = pgd_oe;
                ev_low[n_ev] = lowcnt;
            end
            hicnt = 1;
            if (!busy) idle_rise++;
        end else if (pgc) begin
            hicnt++;
        end
        if (!pgc && prev_pgc) begin
            if (n_ev < 64) ev_high[n_ev] = hicnt;
            n_ev++;
            lowcnt = 1;
        end else if (!pgc) begin
            lowcnt++;
        end
        if (pgd_oe && (!busy || (!pgc && lowcnt > DIV))) bad_oe++;
        if (!busy && prev_busy) tail_low = lowcnt;
        prev_pgc  = pgc;
        prev_busy = busy;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int field(input int first, input int n);
        int v = 0;
        for (int i = 0; i < n; i++) v = v | (int'(ev_bit[first + i]) << i);
        return v;
    endfunction

    // Send one request and wait for the sequence to finish
    task automatic do_req(input logic [1:0] k, input logic [3:0] c, input logic [15:0] d);
        @(negedge clk);
        n_ev = 0; tail_low = 0;
        req_valid = 1'b1; req_kind = k; req_cmd = c; req_data = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Shared checks on the first command and payload of a sequence
    task automatic check_head(input int cmd, input int data, input string tag);
        int bad_hi = 0, bad_lo = 0, no_oe = 0;
        check(field(0, 4) == cmd, {tag, " command bits"}, field(0, 4), cmd);
        check(field(4, 16) == data, {tag, " payload bits"}, field(4, 16), data);
        for (int i = 0; i < 20; i++) begin
            if (ev_high[i] != DIV) bad_hi++;
            if (i != 0 && i != 4 && ev_low[i] != DIV) bad_lo++;
            if (!ev_oe[i]) no_oe++;
        end
        check(bad_hi == 0, "R3 high phase length", bad_hi, 0);
        check(bad_lo == 0, "R3 low phase length", bad_lo, 0);
        check(no_oe == 0, "R2 oe at rising edge", no_oe, 0);
        check(ev_low[4] >= P5, "R4 command to payload gap", ev_low[4], P5);
    endtask

    task automatic t_reset;
        check(pgc == 1'b0, "R1 pgc after reset", pgc, 0);
        check(pgd_oe == 1'b0, "R1 oe after reset", pgd_oe, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_raw(input logic [3:0] c, input logic [15:0] d);
        do_req(2'd0, c, d);
        check(n_ev == 20, "R2 raw pulse count", n_ev, 20);
        check_head(int'(c), int'(d), "R2 raw");
        check(tail_low > P5A, "R10 busy held after last pulse", tail_low, P5A + 1);
        check(bad_oe == 0, "R11 data line released", bad_oe, 0);
    endtask

    task automatic t_prog;
        logic [15:0] w [4];
        int ready_seen = 0, bad_hi = 0, ev_before;
        w[0] = 16'h1234; w[1] = 16'hBEEF; w[2] = 16'h0F0F; w[3] = 16'hC001;
        for (int k = 0; k < 3; k++) begin
            do_req(2'd1, 4'd0, w[k]);
            check(n_ev == 20, "R5 load pulse count", n_ev, 20);
            check_head(4'b1101, int'(w[k]), "R5 load");
            if (k == 0) begin
                // R6: a raw request offered mid-fill must be held off
                ev_before = n_ev;
                @(negedge clk);
                req_valid = 1'b1; req_kind = 2'd0; req_cmd = 4'b0000; req_data = 16'h5555;
                for (int j = 0; j < 20; j++) begin
                    @(negedge clk);
                    if (req_ready) ready_seen++;
                end
                req_valid = 1'b0;
                check(ready_seen == 0, "R6 ready held low mid-fill", ready_seen, 0);
                check(n_ev == ev_before, "R6 no pulses for held request", n_ev, ev_before);
            end
        end
        do_req(2'd1, 4'd0, w[3]);
        check(n_ev == 40, "R7 start sequence pulse count", n_ev, 40);
        check_head(4'b1111, int'(w[3]), "R5 start");
        check(ev_low[20] >= P5A, "R4 payload to NOP gap", ev_low[20], P5A);
        check(field(20, 4) == 0, "R7 NOP command bits", field(20, 4), 0);
        for (int i = 20; i < 23; i++) if (ev_high[i] != DIV) bad_hi++;
        check(bad_hi == 0, "R7 first NOP pulses normal", bad_hi, 0);
        check(ev_high[23] == P9, "R7 stretched pulse length", ev_high[23], P9);
        check(ev_low[24] >= P10, "R8 discharge low time", ev_low[24], P10);
        check(field(24, 16) == 0, "R8 zero payload", field(24, 16), 0);
        check(bad_oe == 0, "R11 released during hold", bad_oe, 0);
    endtask

    task automatic t_erase;
        int bad_hi = 0;
        do_req(2'd2, 4'b1100, 16'h8080);
        check(n_ev == 40, "R9 erase pulse count", n_ev, 40);
        check_head(4'b1100, 16'h8080, "R9 erase");
        check(field(20, 4) == 0, "R9 NOP command bits", field(20, 4), 0);
        for (int i = 20; i < 24; i++) if (ev_high[i] != DIV) bad_hi++;
        check(bad_hi == 0, "R9 NOP pulses not stretched", bad_hi, 0);
        check(ev_low[24] >= P11 + P10, "R9 erase plus discharge hold", ev_low[24], P11 + P10);
        check(field(24, 16) == 0, "R9 zero payload", field(24, 16), 0);
        check(tail_low > P5A, "R10 busy held after erase", tail_low, P5A + 1);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw(4'b0110, 16'hA5C3);
        t_raw(4'b1001, 16'h0F01);
        t_prog();
        t_erase();
        check(idle_rise == 0, "R10 no clock while idle", idle_rise, 0);
        check(bad_oe == 0, "R11 release overall", bad_oe, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule